// File: doc/BRIEF.md
# Late-Write Pipelined SRAM Core

This block is a single-clock synchronous memory. Commands are captured on the rising edge. The word address, chip select, write enable and four byte-lane enables arrive together. The data for a write follows one cycle after its command. Each word is 36 bits, split into four 9-bit lanes. The storage is organised as two ways that share one word address. A way-select bit picks one half of the 72-bit pair.

A write is not put into the storage straight away. It is posted into a one-entry buffer, and it moves into the array only when the data of the next write arrives. Every read merges the buffered lanes over the array contents, so a read always returns the newest value, even right after the write.

A read result lands in an output register on the edge after the read command. It is then driven during the following cycle. In the late way-select configuration, the way bit is taken one edge after the rest of the command, together with write data or just before read data is captured. An asynchronous output enable and a sleep input gate the read driver without a clock edge.

Top module: `lw_sram`

## Requirements
- R1: Chip select `sel_n` and write enable `wr_n` are active low and sampled on the rising edge. A write command at edge k takes its data from `wdata` at edge k+1.
- R2: A read command at edge k is captured at edge k+1. The word is then driven on `rdata` with `rdata_oe` high until edge k+2.
- R3: A read returns the newest written value of its word. This holds when the write is still held in the posting buffer, including a read issued on the very next edge after the write command.
- R4: Bit `be_n[i]` low writes lane i, which is bits 9i+8 down to 9i of the word. Lanes whose bit is high keep their earlier value. All 16 lane combinations are legal.
- R5: With `LATE_SEL=0`, `way` is sampled with the command. With `LATE_SEL=1`, `way` is sampled on the edge after the command, for both reads and writes. Value 0 selects way 0 and value 1 selects way 1.
- R6: In the cycle that would carry the result of a deselect (`sel_n` high) or a write command, `rdata_oe` is low.
- R7: While `oe_n` is high, `rdata_oe` is low. `oe_n` acts at once, without waiting for a clock edge, and a read issued while `oe_n` is high drives nothing.
- R8: While `sleep` is high, `rdata_oe` is low. A command sampled while `sleep` is high does nothing to the stored data.
- R9: Reset makes `rdata_oe` low and empties the posting buffer without writing it to the array. Data already in the array is kept, so a word whose last write was still posted reads back its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write enable, active low; high means read |
| addr | input | AW | Word address within a way |
| way | input | 1 | Way select; timing set by LATE_SEL |
| be_n | input | LANES | Byte-lane write enables, active low |
| wdata | input | LANES*LANE_W | Write data, one cycle after its command |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Sleep request, active high |
| rdata | output | LANES*LANE_W | Read data from the output register |
| rdata_oe | output | 1 | High when rdata is being driven |

## Verification
A command sampled at edge k has its outcome held from edge k+1 to edge k+2, and write data for it is due at edge k+1. The bench therefore drives each command at a falling edge and checks the previous command's outcome at the next falling edge. That falling edge is half a cycle after the capture edge, so the sample is stable. In the late-select instance, the bench presents the way bit during the following command's cycle. A reference model applies every write at once and keeps the last one pending, so that a reset drop can be predicted. The output-enable checks are made between clock edges, one time step after `oe_n` changes.

// File: rtl/lw_sram_pkg.sv
package lw_sram_pkg;

    typedef enum logic [1:0] {
        LW_IDLE  = 2'd0,
        LW_READ  = 2'd1,
        LW_WRITE = 2'd2
    } lw_op_e;

    localparam int NWAYS = 2;

endpackage

// File: rtl/lw_sram_cmd.sv
module lw_sram_cmd
    import lw_sram_pkg::*;
#(
    parameter int AW    = 4,
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_n,
    input  logic             wr_n,
    input  logic [AW-1:0]    addr,
    input  logic             way,
    input  logic [LANES-1:0] be_n,
    input  logic             sleep,
    output logic             rd_vld,
    output logic             wr_vld,
    output logic [AW-1:0]    cmd_addr,
    output logic             cmd_way,
    output logic [LANES-1:0] cmd_be
);

    typedef struct packed {
        logic             rd;
        logic             wr;
        logic [AW-1:0]    addr;
        logic             way;
        logic [LANES-1:0] be;
    } cmd_st_t;

    cmd_st_t st_d, st_q;
    lw_op_e  op;

    always_comb begin
        op = LW_IDLE;
        if (!sleep && !sel_n) begin
            op = wr_n ? LW_READ : LW_WRITE;
        end
        st_d    = st_q;
        st_d.rd = (op == LW_READ);
        st_d.wr = (op == LW_WRITE);
        if (op != LW_IDLE) begin
            st_d.addr = addr;
            st_d.way  = way;
            st_d.be   = ~be_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_vld   = st_q.rd;
    assign wr_vld   = st_q.wr;
    assign cmd_addr = st_q.addr;
    assign cmd_way  = st_q.way;
    assign cmd_be   = st_q.be;

    // R1: an awake write command is always posted for its data edge
    p_write_posts_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n && !wr_n && !sleep) |=> wr_vld);

    // R8: nothing enters the pipeline while asleep
    p_sleep_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> (!rd_vld && !wr_vld));

endmodule

// File: rtl/lw_sram_array.sv
module lw_sram_array
    import lw_sram_pkg::*;
#(
    parameter int AW     = 4,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                              clk,
    input  logic                              we,
    input  logic [AW-1:0]                     waddr,
    input  logic                              wway,
    input  logic [LANES-1:0]                  wbe,
    input  logic [LANES*LANE_W-1:0]           wdata,
    input  logic [AW-1:0]                     raddr,
    output logic [NWAYS-1:0][LANES*LANE_W-1:0] rword
);

    localparam int ENTRIES = NWAYS * (2 ** AW);

    // one storage per lane so each lane has a single writer
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LANE_W-1:0] lane_mem [ENTRIES];

        always_ff @(posedge clk) begin
            if (we && wbe[l]) begin
                lane_mem[{wway, waddr}] <= wdata[l*LANE_W +: LANE_W];
            end
        end

        for (genvar w = 0; w < NWAYS; w++) begin : g_rd
            assign rword[w][l*LANE_W +: LANE_W] = lane_mem[{1'(w), raddr}];
        end
    end

endmodule

// File: rtl/lw_sram_wbuf.sv
module lw_sram_wbuf
    import lw_sram_pkg::*;
#(
    parameter int AW       = 4,
    parameter int LANES    = 4,
    parameter int LANE_W   = 9,
    parameter bit LATE_SEL = 1'b0
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr_vld,
    input  logic [AW-1:0]                      wr_addr,
    input  logic                               wr_way,
    input  logic [LANES-1:0]                   wr_be,
    input  logic                               way_in,
    input  logic [LANES*LANE_W-1:0]            wdata,
    input  logic [AW-1:0]                      rd_addr,
    input  logic [NWAYS-1:0][LANES*LANE_W-1:0] arr_word,
    output logic [NWAYS-1:0][LANES*LANE_W-1:0] fwd_word,
    output logic                               mem_we,
    output logic [AW-1:0]                      mem_addr,
    output logic                               mem_way,
    output logic [LANES-1:0]                   mem_be,
    output logic [LANES*LANE_W-1:0]            mem_wdata
);

    localparam int DW = LANES * LANE_W;

    typedef struct packed {
        logic             vld;
        logic [AW-1:0]    addr;
        logic             way;
        logic [LANES-1:0] be;
        logic [DW-1:0]    data;
    } buf_st_t;

    buf_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_vld) begin
            st_d.vld  = 1'b1;
            st_d.addr = wr_addr;
            st_d.way  = LATE_SEL ? way_in : wr_way;
            st_d.be   = wr_be;
            st_d.data = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // the held entry retires when the next one replaces it
    assign mem_we    = wr_vld && st_q.vld;
    assign mem_addr  = st_q.addr;
    assign mem_way   = st_q.way;
    assign mem_be    = st_q.be;
    assign mem_wdata = st_q.data;

    for (genvar w = 0; w < NWAYS; w++) begin : g_way
        logic hit;
        assign hit = st_q.vld && (st_q.addr == rd_addr) && (st_q.way == 1'(w));
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            assign fwd_word[w][l*LANE_W +: LANE_W] = (hit && st_q.be[l])
                ? st_q.data[l*LANE_W +: LANE_W]
                : arr_word[w][l*LANE_W +: LANE_W];
        end
    end

    // R9: the held entry only changes when a new write's data lands
    p_buf_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_vld |=> ($stable(st_q.vld) && $stable(st_q.data) && $stable(st_q.addr)));

endmodule

// File: rtl/lw_sram_rdout.sv
module lw_sram_rdout
    import lw_sram_pkg::*;
#(
    parameter int DW       = 36,
    parameter bit LATE_SEL = 1'b0
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      rd_vld,
    input  logic                      rd_way,
    input  logic                      way_in,
    input  logic [NWAYS-1:0][DW-1:0]  word,
    input  logic                      oe_n,
    input  logic                      sleep,
    output logic [DW-1:0]             rdata,
    output logic                      rdata_oe
);

    typedef struct packed {
        logic          vld;
        logic [DW-1:0] data;
    } out_st_t;

    out_st_t st_d, st_q;
    logic    pick;

    always_comb begin
        pick     = LATE_SEL ? way_in : rd_way;
        st_d     = st_q;
        st_d.vld = rd_vld;
        if (rd_vld) begin
            st_d.data = pick ? word[1] : word[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata    = st_q.data;
    assign rdata_oe = st_q.vld && !oe_n && !sleep;

    // R2: a read in the array stage is always followed by a loaded output
    p_read_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_vld |=> st_q.vld);

endmodule

// File: rtl/lw_sram.sv
module lw_sram
    import lw_sram_pkg::*;
#(
    parameter int AW       = 4,
    parameter int LANES    = 4,
    parameter int LANE_W   = 9,
    parameter bit LATE_SEL = 1'b0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sel_n,
    input  logic                    wr_n,
    input  logic [AW-1:0]           addr,
    input  logic                    way,
    input  logic [LANES-1:0]        be_n,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic                    oe_n,
    input  logic                    sleep,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic                    rdata_oe
);

    localparam int DW = LANES * LANE_W;

    logic                        rd_vld, wr_vld, cmd_way;
    logic [AW-1:0]               cmd_addr;
    logic [LANES-1:0]            cmd_be;
    logic [NWAYS-1:0][DW-1:0]    arr_word, fwd_word;
    logic                        mem_we, mem_way;
    logic [AW-1:0]               mem_addr;
    logic [LANES-1:0]            mem_be;
    logic [DW-1:0]               mem_wdata;

    lw_sram_cmd #(.AW(AW), .LANES(LANES)) u_cmd (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .wr_n(wr_n), .addr(addr),
        .way(way), .be_n(be_n), .sleep(sleep), .rd_vld(rd_vld), .wr_vld(wr_vld),
        .cmd_addr(cmd_addr), .cmd_way(cmd_way), .cmd_be(cmd_be)
    );

    lw_sram_array #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk(clk), .we(mem_we), .waddr(mem_addr), .wway(mem_way), .wbe(mem_be),
        .wdata(mem_wdata), .raddr(cmd_addr), .rword(arr_word)
    );

    lw_sram_wbuf #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W), .LATE_SEL(LATE_SEL)) u_wbuf (
        .clk(clk), .rst_n(rst_n), .wr_vld(wr_vld), .wr_addr(cmd_addr),
        .wr_way(cmd_way), .wr_be(cmd_be), .way_in(way), .wdata(wdata),
        .rd_addr(cmd_addr), .arr_word(arr_word), .fwd_word(fwd_word),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_way(mem_way),
        .mem_be(mem_be), .mem_wdata(mem_wdata)
    );

    lw_sram_rdout #(.DW(DW), .LATE_SEL(LATE_SEL)) u_rdout (
        .clk(clk), .rst_n(rst_n), .rd_vld(rd_vld), .rd_way(cmd_way),
        .way_in(way), .word(fwd_word), .oe_n(oe_n), .sleep(sleep),
        .rdata(rdata), .rdata_oe(rdata_oe)
    );

    // R6: a write command never leads to a driven result
    p_no_drive_after_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n && !wr_n) |=> ##1 !rdata_oe);

endmodule

// File: tb/lw_sram_bench.sv
module lw_sram_bench;

    localparam int AW = 4;
    localparam int DW = 36;
    localparam int NENT = 2 * (2 ** AW);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sel_n = 1'b1, wr_n = 1'b1, oe_n = 1'b0, sleep = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          way_a = 1'b0, way_b = 1'b0;
    logic [3:0]    be_n = 4'hf;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata_a, rdata_b;
    logic          oe_a, oe_b;

    always #5 clk = ~clk;

    lw_sram #(.AW(AW), .LATE_SEL(1'b0)) u_lw_sram (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .wr_n(wr_n), .addr(addr),
        .way(way_a), .be_n(be_n), .wdata(wdata), .oe_n(oe_n), .sleep(sleep),
        .rdata(rdata_a), .rdata_oe(oe_a)
    );

    lw_sram #(.AW(AW), .LATE_SEL(1'b1)) u_lw_sram_ls (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .wr_n(wr_n), .addr(addr),
        .way(way_b), .be_n(be_n), .wdata(wdata), .oe_n(oe_n), .sleep(sleep),
        .rdata(rdata_b), .rdata_oe(oe_b)
    );

    int n_vec = 0, n_bad = 0;
    bit done = 0;

    // reference model: committed words plus one pending write
    logic [DW-1:0] ref_mem [NENT];
    bit            pend_vld = 0;
    int            pend_idx = 0;
    logic [3:0]    pend_be = '0;
    logic [DW-1:0] pend_data = '0;

    // previous command, whose result is checked one step later
    int            p_op = 0;
    int            p_way = 0;
    logic [DW-1:0] p_wd = '0, p_exp = '0;
    string         p_tag = "R6";

    function automatic logic [DW-1:0] merge(logic [DW-1:0] o, logic [DW-1:0] n, logic [3:0] be);
        logic [DW-1:0] r = o;
        for (int l = 0; l < 4; l++) if (be[l]) r[l*9 +: 9] = n[l*9 +: 9];
        return r;
    endfunction

    function automatic logic [DW-1:0] pat(int a, int w, int salt);
        logic [DW-1:0] r;
        for (int l = 0; l < 4; l++) r[l*9 +: 9] = 9'((a*7 + w*61 + l*113 + salt*29 + 1) % 512);
        return r;
    endfunction

    function automatic logic [DW-1:0] model_read(int idx);
        logic [DW-1:0] r = ref_mem[idx];
        if (pend_vld && pend_idx == idx) r = merge(r, pend_data, pend_be);
        return r;
    endfunction

    task automatic model_write(int idx, logic [3:0] be, logic [DW-1:0] d);
        if (pend_vld) ref_mem[pend_idx] = merge(ref_mem[pend_idx], pend_data, pend_be);
        pend_vld = 1; pend_idx = idx; pend_be = be; pend_data = d;
    endtask

    task automatic chk(logic [DW-1:0] act, logic [DW-1:0] exp, string what);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    // check the result of the previous command at the current falling edge
    task automatic check_prev();
        logic e_oe;
        e_oe = (p_op == 1) && !oe_n && !sleep;
        chk(DW'(oe_a), DW'(e_oe), {p_tag, " drive (late write)"});
        chk(DW'(oe_b), DW'(e_oe), {p_tag, " drive (late select)"});
        if (e_oe) begin
            chk(rdata_a, p_exp, {p_tag, " data (late write)"});
            chk(rdata_b, p_exp, {p_tag, " data (late select)"});
        end
    endtask

    // op: 0 idle, 1 read, 2 write; called at a falling edge
    task automatic step(int op, int a, int w, logic [3:0] bn, logic [DW-1:0] d, string tag);
        int eff;
        logic [DW-1:0] e;
        eff   = sleep ? 0 : op;
        sel_n = (op == 0);
        wr_n  = (op != 2);
        addr  = AW'(a);
        be_n  = bn;
        way_a = 1'(w);
        way_b = 1'(p_way);
        wdata = (p_op == 2) ? p_wd : '0;
        e = '0;
        if (eff == 2) model_write(w * (2 ** AW) + a, ~bn, d);
        if (eff == 1) e = model_read(w * (2 ** AW) + a);
        @(posedge clk);
        @(negedge clk);
        check_prev();
        p_op = eff; p_way = w; p_wd = d; p_exp = e; p_tag = tag;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        sel_n = 1'b1; wr_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(DW'(oe_a), '0, "R9 drive in reset (late write)");
        chk(DW'(oe_b), '0, "R9 drive in reset (late select)");
        pend_vld = 0;
        p_op = 0; p_tag = "R9";
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < NENT; i++) ref_mem[i] = '0;
        @(negedge clk);
        do_reset();

        // R1 / R5: fill every word of both ways
        for (int w = 0; w < 2; w++)
            for (int a = 0; a < 2 ** AW; a++)
                step(2, a, w, 4'h0, pat(a, w, 0), "R6 after write");
        step(0, 0, 0, 4'hf, '0, "R6 deselect");

        // R2 / R5: read back alternating ways
        for (int a = 0; a < 2 ** AW; a++)
            for (int w = 0; w < 2; w++)
                step(1, a, w, 4'hf, '0, "R2 R5 readback");

        // R3: read right after write, and after two writes
        step(2, 3, 1, 4'h0, pat(3, 1, 5), "R6");
        step(1, 3, 1, 4'hf, '0, "R3 forward next edge");
        step(2, 9, 0, 4'h0, pat(9, 0, 6), "R6");
        step(2, 10, 0, 4'h0, pat(10, 0, 6), "R6");
        step(1, 9, 0, 4'hf, '0, "R3 after second write");
        step(1, 10, 0, 4'hf, '0, "R3 held entry");
        step(1, 3, 1, 4'hf, '0, "R3 committed");

        // R4: every lane mask, read immediately and from the other way
        for (int m = 0; m < 16; m++) begin
            step(2, 5, 1, 4'(m), pat(5, 1, 10 + m), "R6");
            step(1, 5, 1, 4'hf, '0, "R4 lane mask");
        end
        step(1, 5, 0, 4'hf, '0, "R4 other way kept");

        // R7: asynchronous output enable
        step(1, 2, 0, 4'hf, '0, "R7");
        oe_n = 1'b1; #1;
        chk(DW'(oe_a), '0, "R7 async off (late write)");
        chk(DW'(oe_b), '0, "R7 async off (late select)");
        oe_n = 1'b0; #1;
        chk(DW'(oe_a), 1, "R7 async on (late write)");
        chk(DW'(oe_b), 1, "R7 async on (late select)");
        step(0, 0, 0, 4'hf, '0, "R6 deselect");
        oe_n = 1'b1;
        step(1, 4, 1, 4'hf, '0, "R7 read with enable off");
        step(0, 0, 0, 4'hf, '0, "R6");
        oe_n = 1'b0;

        // R8: sleep blocks drive and commands
        step(1, 6, 0, 4'hf, '0, "R8 drive blocked");
        sleep = 1'b1;
        step(0, 0, 0, 4'hf, '0, "R8");
        step(2, 2, 0, 4'h0, pat(2, 0, 40), "R8 ignored write");
        step(0, 0, 0, 4'hf, '0, "R8");
        sleep = 1'b0;
        step(1, 2, 0, 4'hf, '0, "R8 word unchanged");
        step(0, 0, 0, 4'hf, '0, "R6");

        // R9: reset drops the held write, keeps the array
        step(2, 7, 0, 4'h0, pat(7, 0, 50), "R6");
        step(2, 8, 0, 4'h0, pat(8, 0, 50), "R6");
        step(2, 7, 0, 4'h0, pat(7, 0, 51), "R6");
        step(0, 0, 0, 4'hf, '0, "R6");
        step(0, 0, 0, 4'hf, '0, "R6");
        do_reset();
        step(1, 7, 0, 4'hf, '0, "R9 held write dropped");
        step(1, 8, 0, 4'hf, '0, "R9 array kept");
        step(0, 0, 0, 4'hf, '0, "R6");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule